// File: doc/BRIEF.md
# Serial-Loaded Switch Control Register

This block holds the low-voltage control word for a bank of analog switches. A serial bit stream arrives with its own shift clock. Each rising edge of that clock moves the bit into an N-stage shift register. The last stage is brought out as a serial output, so several blocks can be daisy-chained. An active-low latch-enable input sets how the register reaches the switch enables. While it is low, the enables follow the shift register. When it rises, they freeze and hold their values while it stays high. A clear input forces every enable off at once and overrides all other inputs.

The shift clock, data and latch-enable inputs are treated as slow signals. They are resynchronised into a fast system clock domain, and the edges of the shift clock are detected there. The transparent latch is therefore built from an ordinary hold register plus a bypass multiplexer, and the design contains no level-sensitive storage. The clear acts on the enables combinationally and does not touch the shift register.

Top module: `swctl_serial_reg`

## Requirements
- R1: On each rising edge of the serial clock, the register stage at index 0 takes the serial data input and every stage k>0 takes the old value of stage k-1. Without a rising edge the register keeps its contents.
- R2: The serial output equals stage N-1. After reset, a 1 shifted in followed by N-1 zeros shows on the serial output only after the Nth rising edge.
- R3: While latch enable is low and clear is low, switch enable n equals register stage n (1 = on, 0 = off), also part way through a load.
- R4: When latch enable rises, the switch enables keep the values they had. Shifting new data while latch enable is high leaves them unchanged.
- R5: While clear is high, all switch enables are 0, in the same time step as clear goes high. The shift register, seen on the serial output, is not changed, and shifting goes on during clear.
- R6: After clear falls, the enables follow R3/R4 again: with latch enable high they show the value held before clear; with it low they show the current register.
- R7: After reset, all switch enables and the serial output are 0.
- R8: Every channel is independent. Any N-bit pattern loaded with latch enable low appears bit for bit, with bit n driving switch n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples all control inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock; the register shifts on its rising edge |
| sdata_i | input | 1 | Serial data input |
| le_ni | input | 1 | Latch enable, active low: low = transparent, high = hold |
| clr_i | input | 1 | Asynchronous clear, forces all enables off |
| sdata_o | output | 1 | Serial chain output (last stage) |
| sw_en_o | output | N_CH | Switch enables, 1 = on |

## Verification
Each serial-clock or data change passes through SYNC_STAGES flops and then the edge detector, so the register and the serial output move on the (SYNC_STAGES+1)th system edge after the input change. A change of latch enable reaches the enables after SYNC_STAGES edges. A change of clear reaches them within the same time step. The bench holds every input for six system cycles before it toggles the next one and samples on the falling edge at the end of that wait, which lies well past both delays. Clear is checked one time unit after it is driven, with no clock edge in between.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
  // synchronised control inputs
  typedef struct packed {
    logic sclk;
    logic sdata;
    logic le_n;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);
  localparam ctl_t CTL_IDLE = '{sclk: 1'b0, sdata: 1'b0, le_n: 1'b1};
endpackage

// File: rtl/swctl_sync.sv
module swctl_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= RST_VAL;
        else         pipe_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= RST_VAL;
        else         pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/swctl_shreg.sv
module swctl_shreg #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_i,
  input  logic            sdata_i,
  output logic [N_CH-1:0] sr_o
);
  logic [N_CH-1:0] sr_q;

  for (genvar k = 0; k < N_CH; k++) begin : g_bit
    logic src;
    if (k == 0) begin : g_head
      assign src = sdata_i;
    end else begin : g_tail
      assign src = sr_q[k-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sr_q[k] <= 1'b0;
      else if (shift_i) sr_q[k] <= src;
    end
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/swctl_hold.sv
module swctl_hold #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hold_i,
  input  logic            clr_i,
  input  logic [N_CH-1:0] sr_i,
  output logic [N_CH-1:0] sw_en_o
);
  logic [N_CH-1:0] hold_q;

  // tracks the register while transparent, freezes when hold asserts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (!hold_i) hold_q <= sr_i;
  end

  always_comb begin
    if (clr_i)       sw_en_o = '0;
    else if (hold_i) sw_en_o = hold_q;
    else             sw_en_o = sr_i;
  end
endmodule

// File: rtl/swctl_serial_reg.sv
module swctl_serial_reg #(
  parameter int unsigned N_CH        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sclk_i,
  input  logic            sdata_i,
  input  logic            le_ni,
  input  logic            clr_i,
  output logic            sdata_o,
  output logic [N_CH-1:0] sw_en_o
);
  import swctl_pkg::*;

  ctl_t            ctl_raw, ctl_s;
  logic            sclk_d;
  logic            shift_s;
  logic            le_hold_s;
  logic [N_CH-1:0] sr_q;

  assign ctl_raw = '{sclk: sclk_i, sdata: sdata_i, le_n: le_ni};

  swctl_sync #(
    .W      (CTL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTL_IDLE)
  ) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= ctl_s.sclk;
  end

  assign shift_s   = ctl_s.sclk & ~sclk_d;
  assign le_hold_s = ctl_s.le_n;

  swctl_shreg #(.N_CH(N_CH)) shreg_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_s),
    .sdata_i(ctl_s.sdata),
    .sr_o   (sr_q)
  );

  swctl_hold #(.N_CH(N_CH)) hold_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (le_hold_s),
    .clr_i  (clr_i),
    .sr_i   (sr_q),
    .sw_en_o(sw_en_o)
  );

  assign sdata_o = sr_q[N_CH-1];
endmodule

// File: rtl/swctl_chk.sv
module swctl_chk #(
  parameter int unsigned N_CH = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            clr_i,
  input logic            shift_i,
  input logic            hold_i,
  input logic [N_CH-1:0] sr_i,
  input logic [N_CH-1:0] sw_i,
  input logic            sdata_o_i
);
  AST_SHIFT_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> sr_i[N_CH-1:1] == $past(sr_i[N_CH-2:0]));       // R1
  AST_NO_EDGE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sr_i));                                 // R1
  AST_CHAIN_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> sdata_o_i == $past(sr_i[N_CH-2]));               // R2
  AST_TRANSPARENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !hold_i) |-> sw_i == sr_i);                       // R3
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && $past(hold_i) && !clr_i && !$past(clr_i)) |-> $stable(sw_i)); // R4
  AST_CLEAR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> sw_i == '0);                                       // R5
endmodule

bind swctl_serial_reg swctl_chk #(.N_CH(N_CH)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_i    (clr_i),
  .shift_i  (shift_s),
  .hold_i   (le_hold_s),
  .sr_i     (sr_q),
  .sw_i     (sw_en_o),
  .sdata_o_i(sdata_o)
);

// File: tb/swctl_serial_reg_tb.sv
module swctl_serial_reg_tb_top;
  localparam int unsigned N_CH   = 8;
  localparam int unsigned CLK_NS = 10;
  localparam int unsigned HOLD_CYC = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, le_n = 1'b1, clr = 1'b0;
  logic sdata_o;
  logic [N_CH-1:0] sw_en;

  int unsigned n_chk = 0, n_fail = 0;
  logic [N_CH-1:0] exp_sr = '0;

  always #(CLK_NS/2) clk = ~clk;

  swctl_serial_reg #(.N_CH(N_CH), .SYNC_STAGES(2)) dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .sclk_i (sclk),
    .sdata_i(sdata),
    .le_ni  (le_n),
    .clr_i  (clr),
    .sdata_o(sdata_o),
    .sw_en_o(sw_en)
  );

  task automatic check(input string req, input logic [N_CH-1:0] act, input logic [N_CH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (HOLD_CYC) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    sdata = b;
    settle();
    sclk = 1'b1;
    settle();
    sclk = 1'b0;
    settle();
    exp_sr = {exp_sr[N_CH-2:0], b};
  endtask

  task automatic load_word(input logic [N_CH-1:0] w, input bit per_bit);
    for (int i = N_CH-1; i >= 0; i--) begin
      shift_bit(w[i]);
      if (per_bit) begin
        check("R1 R3 partial load", sw_en, exp_sr);
        check("R2 chain out", {{(N_CH-1){1'b0}}, sdata_o}, {{(N_CH-1){1'b0}}, exp_sr[N_CH-1]});
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [N_CH-1:0] held;
    repeat (3) @(negedge clk);
    check("R7 reset enables", sw_en, '0);
    check("R7 reset chain", {{(N_CH-1){1'b0}}, sdata_o}, '0);
    rst_n = 1'b1;
    settle();
    check("R7 after release", sw_en, '0);

    // first bit reaches chain output only on the Nth edge
    le_n = 1'b0;
    shift_bit(1'b1);
    for (int i = 1; i < N_CH; i++) begin
      check("R2 not yet out", {{(N_CH-1){1'b0}}, sdata_o}, '0);
      shift_bit(1'b0);
    end
    check("R2 Nth edge", {{(N_CH-1){1'b0}}, sdata_o}, {{(N_CH-1){1'b0}}, 1'b1});

    // exhaustive pattern sweep, transparent
    for (int w = 0; w < (1 << N_CH); w++) begin
      load_word(w[N_CH-1:0], w < 4);
      check("R8 R3 word", sw_en, w[N_CH-1:0]);
      check("R2 chain", {{(N_CH-1){1'b0}}, sdata_o}, {{(N_CH-1){1'b0}}, w[N_CH-1]});
    end

    // single-channel independence
    for (int n = 0; n < N_CH; n++) begin
      load_word(N_CH'(1) << n, 1'b0);
      check("R8 one hot", sw_en, N_CH'(1) << n);
    end

    // hold on latch-enable rise, shifting has no effect
    load_word(8'hA5, 1'b0);
    le_n = 1'b1;
    settle();
    held = 8'hA5;
    check("R4 captured", sw_en, held);
    load_word(8'h3C, 1'b1 == 1'b0);
    check("R4 held while shifting", sw_en, held);
    check("R4 register moved", {{(N_CH-1){1'b0}}, sdata_o}, '0);
    shift_bit(1'b1);
    check("R4 held after extra bit", sw_en, held);

    // clear while holding: immediate, register untouched, shifting continues
    clr = 1'b1;
    #1;
    check("R5 clear immediate", sw_en, '0);
    settle();
    check("R5 chain kept", {{(N_CH-1){1'b0}}, sdata_o}, {{(N_CH-1){1'b0}}, exp_sr[N_CH-1]});
    shift_bit(1'b0);
    check("R5 shift during clear", {{(N_CH-1){1'b0}}, sdata_o}, {{(N_CH-1){1'b0}}, exp_sr[N_CH-1]});
    check("R5 still off", sw_en, '0);
    clr = 1'b0;
    #1;
    check("R6 held value back", sw_en, held);
    settle();
    le_n = 1'b0;
    settle();
    check("R6 follows register", sw_en, exp_sr);

    // clear over transparent latch
    load_word(8'hFF, 1'b0);
    clr = 1'b1;
    #1;
    check("R5 clear transparent", sw_en, '0);
    settle();
    clr = 1'b0;
    #1;
    check("R6 transparent after clear", sw_en, 8'hFF);
    settle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule